// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Halt Wake-up

This block collects interrupt requests for a small 8-bit processor core and decides when, and to which address, the core should branch. Each of five peripheral sources raises a one-cycle request pulse that latches a pending bit. Software can read and rewrite both the pending bits and a per-source enable mask through simple write strobes. A master enable bit, driven by strobes from the instruction decoder for enable, disable and return-from-interrupt, gates whether any pending, enabled source may be taken.

When the master enable is set and at least one source is both pending and enabled, the block raises a dispatch request carrying the entry address of the most urgent source. The core answers with an acknowledge. The block then drops that source's pending bit and the master enable, and holds off any further dispatch for the length of the entry sequence. A halt strobe parks the core. The halted state is released as soon as any enabled source is pending, even while the master enable is off, so the core can resume without taking the interrupt.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable mask reads 0x00, the pending register reads 0xE0, and the master enable, halted state and dispatch request are all 0.
- R2: A pulse on request bit k sets pending bit k at the next clock edge. The bit stays set until it is cleared. Pending bits 7..5 always read as 1.
- R3: A pending-register write replaces bits 4..0 with the written data, but a request pulse in the same cycle still sets its bit. An enable-mask write stores all 8 bits.
- R4: The dispatch request is high only when the master enable is set, some bit of (enable AND pending) in 4..0 is set, and no entry sequence is in progress.
- R5: Priority runs from the lowest index upward: bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is joypad. The lowest-numbered pending, enabled bit is selected.
- R6: The vector output is 0x40 + 8 × (selected index): 0x40, 0x48, 0x50, 0x58 or 0x60.
- R7: An acknowledge while the dispatch request is high clears only the selected pending bit and clears the master enable at that edge.
- R8: After an accepted acknowledge, the dispatch request stays low for 5 cycles (the entry sequence). It can rise again no earlier than the 5th edge after the acknowledge edge.
- R9: The enable strobe and the return strobe each set the master enable at the next edge. The disable strobe clears it and wins over a simultaneous enable. An accepted acknowledge clears it and wins over all three.
- R10: The halt strobe sets the halted state at the next edge, unless some enable-AND-pending bit is already set. A halted core is released one edge after an enabled source becomes pending, whatever the master enable.
- R11: A pending source whose enable bit is 0 neither raises the dispatch request nor releases the halted state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request pulses, one per source |
| ie_we_i | input | 1 | Write strobe for the enable mask |
| if_we_i | input | 1 | Write strobe for the pending register |
| wdata_i | input | 8 | Write data for both registers |
| ie_o | output | 8 | Enable mask read value |
| if_o | output | 8 | Pending register read value, upper bits 1 |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| halt_i | input | 1 | Halt strobe |
| ack_i | input | 1 | Core acknowledge of the dispatch request |
| irq_o | output | 1 | Dispatch request |
| vector_o | output | 8 | Entry address of the selected source |
| ime_o | output | 1 | Master enable state |
| halted_o | output | 1 | Halted state |

## Verification
A corrupted pending bit appears on the pending read port one edge after the stimulus. Because dispatch is combinational on the registered state, the same error shows on the request and vector outputs in that same cycle. A wrong master-enable or halted state appears on its own port one edge after the strobe that should have moved it. A miscounted entry sequence shows as the dispatch request rising one cycle early or late after an acknowledge, so the bench samples the request on every cycle of that window. Priority faults show as a wrong vector when several enabled sources are pending at once.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned SRC_CNT = 5;

    // Entry address for a source index.
    function automatic logic [7:0] src_vector(input logic [7:0] base,
                                              input logic [7:0] step,
                                              input logic [2:0] idx);
        return base + step * {5'd0, idx};
    endfunction

endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
    parameter int unsigned N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic             we_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flags_o
);

    logic [N_SRC-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we_i) flags_d = wdata_i;
        flags_d = (flags_d & ~clr_i) | req_i;  // a request is never lost
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    for (genvar k = 0; k < N_SRC; k++) begin : g_chk
        AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[k] |=> flags_o[k]);  // R2
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N_SRC = 5,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N_SRC-1:0] sel_o
);

    always_comb begin
        idx_o = '0;
        sel_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
                sel_o = N_SRC'(1) << i;
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N_SRC     = SRC_CNT,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ENTRY_CYC = 5,
    parameter int unsigned VEC_BASE  = 8'h40,
    parameter int unsigned VEC_STEP  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              ie_we_i,
    input  logic              if_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ie_o,
    output logic [DATA_W-1:0] if_o,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              reti_i,
    input  logic              halt_i,
    input  logic              ack_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] vector_o,
    output logic              ime_o,
    output logic              halted_o
);

    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int unsigned CNT_W = $clog2(ENTRY_CYC + 1);

    typedef struct packed {
        logic              ime;
        logic              halted;
        logic [CNT_W-1:0]  ent;
        logic [DATA_W-1:0] ie;
    } state_t;

    state_t st_d, st_q;

    logic [N_SRC-1:0] flags;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] sel_oh;
    logic [N_SRC-1:0] clr;
    logic [IDX_W-1:0] sel_idx;
    logic             any_pend;
    logic             busy;
    logic             take;

    assign pend = st_q.ie[N_SRC-1:0] & flags;
    assign busy = (st_q.ent != '0);
    assign irq_o = st_q.ime & any_pend & ~busy;
    assign take  = irq_o & ack_i;
    assign clr   = take ? sel_oh : '0;

    irq_prio_enc #(.N_SRC(N_SRC)) u_prio (
        .pend_i (pend),
        .any_o  (any_pend),
        .idx_o  (sel_idx),
        .sel_o  (sel_oh)
    );

    irq_flag_reg #(.N_SRC(N_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .we_i    (if_we_i),
        .wdata_i (wdata_i[N_SRC-1:0]),
        .clr_i   (clr),
        .flags_o (flags)
    );

    always_comb begin
        st_d = st_q;
        if (ie_we_i) st_d.ie = wdata_i;
        if (ei_i || reti_i) st_d.ime = 1'b1;
        if (di_i)           st_d.ime = 1'b0;
        if (take)           st_d.ime = 1'b0;
        if (take)           st_d.ent = CNT_W'(ENTRY_CYC);
        else if (busy)      st_d.ent = st_q.ent - 1'b1;
        st_d.halted = (st_q.halted | halt_i) & ~any_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_o     = st_q.ie;
    assign if_o     = {{(DATA_W - N_SRC){1'b1}}, flags};
    assign ime_o    = st_q.ime;
    assign halted_o = st_q.halted;
    assign vector_o = DATA_W'(VEC_BASE) + DATA_W'(VEC_STEP) * DATA_W'(sel_idx);

    AST_NO_IRQ_WITHOUT_IME: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ime_o);  // R4
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh) && (any_pend == (sel_oh != '0)));  // R5
    AST_ACK_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (!ime_o && !irq_o));  // R7
    AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && ((req_i & sel_oh) == '0)) |=> (($countones(flags) + 1) == $countones($past(flags))));  // R7
    AST_WAKE_ON_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && any_pend) |=> !halted_o);  // R10
    AST_DI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !ime_o);  // R9

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req_i = '0;
    logic       ie_we_i = 1'b0, if_we_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] ie_o, if_o, vector_o;
    logic       ei_i = 1'b0, di_i = 1'b0, reti_i = 1'b0, halt_i = 1'b0, ack_i = 1'b0;
    logic       irq_o, ime_o, halted_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ie_we_i(ie_we_i), .if_we_i(if_we_i),
        .wdata_i(wdata_i), .ie_o(ie_o), .if_o(if_o), .ei_i(ei_i), .di_i(di_i),
        .reti_i(reti_i), .halt_i(halt_i), .ack_i(ack_i), .irq_o(irq_o),
        .vector_o(vector_o), .ime_o(ime_o), .halted_o(halted_o)
    );

    // Inputs change one time unit after a rising edge; outputs are sampled there too.
    task automatic step();
        @(posedge clk);
        #1;
        req_i = '0; ie_we_i = 0; if_we_i = 0; ei_i = 0; di_i = 0;
        reti_i = 0; halt_i = 0; ack_i = 0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 ie", ie_o, 8'h00);
        chk("R1 if", if_o, 8'hE0);
        chk("R1 ime", {7'd0, ime_o}, 8'd0);
        chk("R1 halted", {7'd0, halted_o}, 8'd0);
        chk("R1 irq", {7'd0, irq_o}, 8'd0);
    endtask

    task automatic t_request();
        req_i = 5'b00100; step();
        chk("R2 set", if_o, 8'hE4);
        step();
        chk("R2 hold", if_o, 8'hE4);
    endtask

    task automatic t_write();
        if_we_i = 1; wdata_i = 8'h03; req_i = 5'b10000; step();
        chk("R3 write+req", if_o, 8'hF3);
        ie_we_i = 1; wdata_i = 8'hFF; step();
        chk("R3 ie", ie_o, 8'hFF);
        chk("R4 no ime", {7'd0, irq_o}, 8'd0);
    endtask

    task automatic t_dispatch();
        ei_i = 1; step();
        chk("R9 ei", {7'd0, ime_o}, 8'd1);
        chk("R4 irq", {7'd0, irq_o}, 8'd1);
        chk("R5/R6 vblank first", vector_o, 8'h40);
        di_i = 1; ei_i = 1; step();
        chk("R9 di wins", {7'd0, ime_o}, 8'd0);
        chk("R4 irq off", {7'd0, irq_o}, 8'd0);
        ei_i = 1; step();
        ack_i = 1; step();
        chk("R7 flag cleared", if_o, 8'hF2);
        chk("R7 ime cleared", {7'd0, ime_o}, 8'd0);
        ei_i = 1; step();
        chk("R9 ei again", {7'd0, ime_o}, 8'd1);
        chk("R8 busy e1", {7'd0, irq_o}, 8'd0);
        for (int i = 2; i <= 4; i++) begin
            step();
            chk("R8 busy", {7'd0, irq_o}, 8'd0);
        end
        step();
        chk("R8 released", {7'd0, irq_o}, 8'd1);
        chk("R6 vector stat", vector_o, 8'h48);
        ack_i = 1; reti_i = 1; step();
        chk("R9 ack wins", {7'd0, ime_o}, 8'd0);
        chk("R7 second", if_o, 8'hF0);
        reti_i = 1; step();
        chk("R9 reti", {7'd0, ime_o}, 8'd1);
        for (int i = 0; i < 4; i++) step();
        chk("R6 vector joypad", vector_o, 8'h60);
        chk("R5 irq", {7'd0, irq_o}, 8'd1);
        ack_i = 1; step();
        chk("R7 all clear", if_o, 8'hE0);
    endtask

    task automatic t_prio();
        for (int i = 0; i < 6; i++) step();
        req_i = 5'b01100; ei_i = 1; step();
        chk("R5 timer over serial", vector_o, 8'h50);
        if_we_i = 1; wdata_i = 8'h08; step();
        chk("R6 serial", vector_o, 8'h58);
        di_i = 1; if_we_i = 1; wdata_i = 8'h00; step();
        chk("R3 clear", if_o, 8'hE0);
    endtask

    task automatic t_halt();
        ie_we_i = 1; wdata_i = 8'h01; step();
        halt_i = 1; step();
        chk("R10 halted", {7'd0, halted_o}, 8'd1);
        req_i = 5'b01000; step();
        step();
        chk("R11 masked no wake", {7'd0, halted_o}, 8'd1);
        chk("R11 masked no irq", {7'd0, irq_o}, 8'd0);
        req_i = 5'b00001; step();
        chk("R10 still halted", {7'd0, halted_o}, 8'd1);
        step();
        chk("R10 woke without ime", {7'd0, halted_o}, 8'd0);
        chk("R10 no dispatch", {7'd0, irq_o}, 8'd0);
        halt_i = 1; step();
        chk("R10 halt refused", {7'd0, halted_o}, 8'd0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        t_reset();
        t_request();
        t_write();
        t_dispatch();
        t_prio();
        t_halt();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule